// File: doc/BRIEF.md
# S/PDIF Source Slot Selector

This block sits between an AC-link frame decoder and an S/PDIF sub-frame formatter. In every link frame it picks one pair of PCM slots as the source for the left and right S/PDIF channels. It captures the two chosen samples into holding registers and sets the validity flag that the formatter places in bit 28 of each sub-frame. The flag is decided separately for each sub-frame.

A 2-bit pair code chooses one of four slot pairs, which are not contiguous. Two control bits set the validity policy:

- **Force bit.** When set, both flags are marked invalid.
- **Configuration bit.** When clear, a flag reports both missing link data and transmit errors. When set, it reports only transmit errors.

A transmit error for a channel is a sample that was handed to the formatter but never acknowledged by that channel's `tx_done` pulse before the next frame sync. At each frame sync the block presents the new samples. A one-cycle left strobe comes first, and a one-cycle right strobe follows in the next cycle.

Top module: `spdif_slot_select`

## Requirements
- R1: While `rst` is high and after its release until the first frame sync, both strobes are 0, both samples are 0 and both validity flags are 1.
- R2: Pair code 2'b00 sampled at a frame sync routes slot 3 to the left channel and slot 4 to the right channel.
- R3: Pair code 2'b01 routes slot 7 to the left channel and slot 8 to the right channel.
- R4: Pair code 2'b10 routes slot 6 to the left channel and slot 9 to the right channel.
- R5: Pair code 2'b11 routes slot 10 to the left channel and slot 11 to the right channel.
- R6: A frame sync sampled at clock edge k raises `left_stb` for exactly the cycle after edge k, and raises `right_stb` for exactly the cycle after edge k+1.
- R7: When `force_invalid` is 1 at a frame sync, both validity flags become 1, whatever the value of `vcfg`.
- R8: With `force_invalid`=0 and `vcfg`=0, a channel's flag becomes 0 only if its selected slot tag is 1 and no earlier sample of that channel is still unacknowledged. Otherwise the flag becomes 1.
- R9: With `force_invalid`=0 and `vcfg`=1, a channel's flag becomes 1 only if an earlier sample of that channel is still unacknowledged. A clear slot tag alone leaves the flag at 0.
- R10: When the selected slot's tag is 0 at a frame sync, that channel's sample output keeps its previous value, but the channel is still strobed.
- R11: The pair code is used only at the frame sync. Changes to it between syncs leave the samples, flags and strobes unchanged until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | One-cycle pulse: the slot data and tags of a completed frame are present |
| slot_data | input | NUM_SLOTS*SAMPLE_W | Slot s occupies bits [s*SAMPLE_W +: SAMPLE_W] |
| slot_tag | input | NUM_SLOTS | Bit s set: slot s carried a valid sample in this frame |
| pair_code | input | 2 | Source slot pair selection |
| force_invalid | input | 1 | Forces both validity flags to 1 |
| vcfg | input | 1 | Validity policy: 0 = data and transmit errors, 1 = transmit errors only |
| tx_done_l | input | 1 | Formatter finished sending the left sample |
| tx_done_r | input | 1 | Formatter finished sending the right sample |
| left_sample | output | SAMPLE_W | Held left sample |
| right_sample | output | SAMPLE_W | Held right sample |
| left_stb | output | 1 | New left sample strobe |
| right_stb | output | 1 | New right sample strobe |
| left_valid_flag | output | 1 | Left sub-frame validity bit (1 = invalid) |
| right_valid_flag | output | 1 | Right sub-frame validity bit (1 = invalid) |

## Verification
Both samples and both flags change one edge after the sync is sampled, in the same cycle as `left_stb`. `right_stb` follows one edge later. An acknowledgement counts only if it is sampled at or before the edge that takes in the next sync.

A behavioural model in the bench applies the same edge-by-edge rules. Its expected values are compared with every output at each falling edge, so all values are read half a cycle after they settle. The stimulus covers several phases:

- frames using every pair code;
- random tag masks;
- dropped acknowledgements under both policy settings;
- forced invalidity;
- pair-code changes in mid-frame.

// File: rtl/spdif_sel_pkg.sv
package spdif_sel_pkg;

  localparam int SLOT_IDX_W = 4;

  typedef enum logic [1:0] {
    PAIR_3_4   = 2'b00,
    PAIR_7_8   = 2'b01,
    PAIR_6_9   = 2'b10,
    PAIR_10_11 = 2'b11
  } pair_code_e;

  function automatic logic [SLOT_IDX_W-1:0] left_slot_of(pair_code_e c);
    case (c)
      PAIR_3_4:   left_slot_of = 4'd3;
      PAIR_7_8:   left_slot_of = 4'd7;
      PAIR_6_9:   left_slot_of = 4'd6;
      default:    left_slot_of = 4'd10;
    endcase
  endfunction

  function automatic logic [SLOT_IDX_W-1:0] right_slot_of(pair_code_e c);
    case (c)
      PAIR_3_4:   right_slot_of = 4'd4;
      PAIR_7_8:   right_slot_of = 4'd8;
      PAIR_6_9:   right_slot_of = 4'd9;
      default:    right_slot_of = 4'd11;
    endcase
  endfunction

endpackage

// File: rtl/slot_pair_mux.sv
module slot_pair_mux
  import spdif_sel_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int NUM_SLOTS = 13
) (
  input  logic [NUM_SLOTS*SAMPLE_W-1:0] slot_data,
  input  logic [NUM_SLOTS-1:0]          slot_tag,
  input  logic [1:0]                    code,
  output logic [SAMPLE_W-1:0]           ch_data [2],
  output logic                          ch_tag  [2]
);

  logic [SAMPLE_W-1:0]   slots [NUM_SLOTS];
  logic [SLOT_IDX_W-1:0] idx   [2];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
    assign slots[g] = slot_data[g*SAMPLE_W +: SAMPLE_W];
  end

  assign idx[0] = left_slot_of(pair_code_e'(code));
  assign idx[1] = right_slot_of(pair_code_e'(code));

  for (genvar c = 0; c < 2; c++) begin : g_sel
    assign ch_data[c] = slots[idx[c]];
    assign ch_tag[c]  = slot_tag[idx[c]];
  end

endmodule

// File: rtl/chan_capture.sv
module chan_capture #(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_en,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_tag,
  input  logic                force_inv,
  input  logic                vcfg,
  input  logic                tx_done,
  output logic [SAMPLE_W-1:0] sample,
  output logic                valid_flag
);

  logic pending;
  logic tx_miss;
  logic flag_next;

  assign tx_miss = pending & ~tx_done;

  always_comb begin
    if (force_inv)  flag_next = 1'b1;
    else if (vcfg)  flag_next = tx_miss;
    else            flag_next = ~in_tag | tx_miss;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample     <= '0;
      valid_flag <= 1'b1;
      pending    <= 1'b0;
    end else if (cap_en) begin
      if (in_tag) sample <= in_data;
      valid_flag <= flag_next;
      pending    <= 1'b1;
    end else if (tx_done) begin
      pending    <= 1'b0;
    end
  end

  a_r10_repeat_on_clear_tag: assert property (@(posedge clk) disable iff (rst)
    cap_en && !in_tag |=> $stable(sample));

  a_r7_force_invalid: assert property (@(posedge clk) disable iff (rst)
    cap_en && force_inv |=> valid_flag);

  a_r8_clear_tag_invalid: assert property (@(posedge clk) disable iff (rst)
    cap_en && !force_inv && !vcfg && !in_tag |=> valid_flag);

  a_r9_idle_not_error: assert property (@(posedge clk) disable iff (rst)
    cap_en && !force_inv && vcfg && !pending |=> !valid_flag);

endmodule

// File: rtl/spdif_slot_select.sv
module spdif_slot_select #(
  parameter int SAMPLE_W  = 20,
  parameter int NUM_SLOTS = 13
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          frame_sync,
  input  logic [NUM_SLOTS*SAMPLE_W-1:0] slot_data,
  input  logic [NUM_SLOTS-1:0]          slot_tag,
  input  logic [1:0]                    pair_code,
  input  logic                          force_invalid,
  input  logic                          vcfg,
  input  logic                          tx_done_l,
  input  logic                          tx_done_r,
  output logic [SAMPLE_W-1:0]           left_sample,
  output logic [SAMPLE_W-1:0]           right_sample,
  output logic                          left_stb,
  output logic                          right_stb,
  output logic                          left_valid_flag,
  output logic                          right_valid_flag
);

  localparam int NUM_CH = 2;

  logic [SAMPLE_W-1:0] ch_data   [NUM_CH];
  logic                ch_tag    [NUM_CH];
  logic [SAMPLE_W-1:0] ch_sample [NUM_CH];
  logic                ch_flag   [NUM_CH];
  logic                ch_done   [NUM_CH];

  assign ch_done[0] = tx_done_l;
  assign ch_done[1] = tx_done_r;

  slot_pair_mux #(.SAMPLE_W(SAMPLE_W), .NUM_SLOTS(NUM_SLOTS)) u_mux (
    .slot_data (slot_data),
    .slot_tag  (slot_tag),
    .code      (pair_code),
    .ch_data   (ch_data),
    .ch_tag    (ch_tag)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_capture #(.SAMPLE_W(SAMPLE_W)) u_cap (
      .clk        (clk),
      .rst        (rst),
      .cap_en     (frame_sync),
      .in_data    (ch_data[c]),
      .in_tag     (ch_tag[c]),
      .force_inv  (force_invalid),
      .vcfg       (vcfg),
      .tx_done    (ch_done[c]),
      .sample     (ch_sample[c]),
      .valid_flag (ch_flag[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_stb  <= 1'b0;
      right_stb <= 1'b0;
    end else begin
      left_stb  <= frame_sync;
      right_stb <= left_stb;
    end
  end

  assign left_sample      = ch_sample[0];
  assign right_sample     = ch_sample[1];
  assign left_valid_flag  = ch_flag[0];
  assign right_valid_flag = ch_flag[1];

  a_r6_right_after_left: assert property (@(posedge clk) disable iff (rst)
    right_stb |-> $past(left_stb));

  a_r6_left_single_cycle: assert property (@(posedge clk) disable iff (rst)
    left_stb && !frame_sync |=> !left_stb);

  a_r11_hold_between_syncs: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |=> $stable(left_sample) && $stable(right_sample)
                    && $stable(left_valid_flag) && $stable(right_valid_flag));

endmodule

// File: tb/spdif_slot_select_bench.sv
module spdif_slot_select_bench;

  localparam int W  = 20;
  localparam int NS = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_sync = 1'b0;
  logic [NS*W-1:0] slot_data = '0;
  logic [NS-1:0]   slot_tag  = '0;
  logic [1:0]      pair_code = 2'b00;
  logic force_invalid = 1'b0;
  logic vcfg = 1'b0;
  logic tx_done_l = 1'b0;
  logic tx_done_r = 1'b0;
  logic [W-1:0] left_sample, right_sample;
  logic left_stb, right_stb, left_valid_flag, right_valid_flag;

  always #10 clk = ~clk;

  spdif_slot_select #(.SAMPLE_W(W), .NUM_SLOTS(NS)) u_spdif_slot_select (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .slot_data(slot_data),
    .slot_tag(slot_tag), .pair_code(pair_code), .force_invalid(force_invalid),
    .vcfg(vcfg), .tx_done_l(tx_done_l), .tx_done_r(tx_done_r),
    .left_sample(left_sample), .right_sample(right_sample),
    .left_stb(left_stb), .right_stb(right_stb),
    .left_valid_flag(left_valid_flag), .right_valid_flag(right_valid_flag)
  );

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1";
  bit checking = 1'b0;

  // behavioural reference
  logic [W-1:0] m_sl = '0, m_sr = '0;
  logic m_vl = 1'b1, m_vr = 1'b1, m_stl = 1'b0, m_str = 1'b0;
  bit m_pl = 0, m_pr = 0;

  function automatic int lslot(input logic [1:0] c);
    case (c) 2'b00: return 3; 2'b01: return 7; 2'b10: return 6; default: return 10; endcase
  endfunction
  function automatic int rslot(input logic [1:0] c);
    case (c) 2'b00: return 4; 2'b01: return 8; 2'b10: return 9; default: return 11; endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sl = '0; m_sr = '0; m_vl = 1; m_vr = 1; m_stl = 0; m_str = 0; m_pl = 0; m_pr = 0;
    end else begin
      m_str = m_stl;
      if (frame_sync) begin
        int li, ri;
        bit ml, mr;
        li = lslot(pair_code); ri = rslot(pair_code);
        ml = m_pl && !tx_done_l; mr = m_pr && !tx_done_r;
        if (slot_tag[li]) m_sl = slot_data[li*W +: W];
        if (slot_tag[ri]) m_sr = slot_data[ri*W +: W];
        m_vl = force_invalid ? 1'b1 : (vcfg ? ml : (!slot_tag[li] || ml));
        m_vr = force_invalid ? 1'b1 : (vcfg ? mr : (!slot_tag[ri] || mr));
        m_pl = 1; m_pr = 1; m_stl = 1;
      end else begin
        m_stl = 0;
        if (tx_done_l) m_pl = 0;
        if (tx_done_r) m_pr = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk(left_sample == m_sl, "left_sample", left_sample, m_sl);
      chk(right_sample == m_sr, "right_sample", right_sample, m_sr);
      chk(left_stb == m_stl, "left_stb R6", W'(left_stb), W'(m_stl));
      chk(right_stb == m_str, "right_stb R6", W'(right_stb), W'(m_str));
      chk(left_valid_flag == m_vl, "left_valid_flag", W'(left_valid_flag), W'(m_vl));
      chk(right_valid_flag == m_vr, "right_valid_flag", W'(right_valid_flag), W'(m_vr));
    end
  end

  int frame_no = 0;

  task automatic send_frame(input logic [NS-1:0] tags, input bit drop_l, input bit drop_r,
                            input bit change_code, input logic [1:0] new_code);
    @(negedge clk);
    frame_no++;
    for (int s = 0; s < NS; s++) slot_data[s*W +: W] = {frame_no[11:0], s[7:0]};
    slot_tag = tags;
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    slot_data = '1;
    @(negedge clk);
    if (change_code) pair_code = new_code;
    @(negedge clk);
    tx_done_l = !drop_l; tx_done_r = !drop_r;
    @(negedge clk);
    tx_done_l = 1'b0; tx_done_r = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    checking = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 explicit reset-state check
    chk(left_sample == '0 && right_sample == '0, "R1 samples after reset", left_sample, '0);
    chk(left_valid_flag && right_valid_flag && !left_stb && !right_stb,
        "R1 flags/strobes after reset", W'({left_valid_flag, right_valid_flag}), W'(2'b11));

    phase = "R2"; pair_code = 2'b00; send_frame('1, 0, 0, 0, 0); send_frame('1, 0, 0, 0, 0);
    phase = "R3"; pair_code = 2'b01; send_frame('1, 0, 0, 0, 0); send_frame('1, 0, 0, 0, 0);
    phase = "R4"; pair_code = 2'b10; send_frame('1, 0, 0, 0, 0); send_frame('1, 0, 0, 0, 0);
    phase = "R5"; pair_code = 2'b11; send_frame('1, 0, 0, 0, 0); send_frame('1, 0, 0, 0, 0);

    phase = "R10";
    for (int i = 0; i < 12; i++) begin
      pair_code = i[1:0];
      send_frame(NS'($urandom), 0, 0, 0, 0);
    end

    phase = "R8"; vcfg = 1'b0;
    send_frame('1, 1, 0, 0, 0);
    send_frame('1, 0, 1, 0, 0);
    send_frame('0, 0, 0, 0, 0);
    send_frame('1, 0, 0, 0, 0);

    phase = "R9"; vcfg = 1'b1;
    send_frame('0, 0, 0, 0, 0);
    send_frame('1, 1, 1, 0, 0);
    send_frame('0, 0, 0, 0, 0);
    send_frame('1, 0, 0, 0, 0);

    phase = "R7"; force_invalid = 1'b1;
    send_frame('1, 0, 0, 0, 0);
    vcfg = 1'b0;
    send_frame('1, 0, 0, 0, 0);
    force_invalid = 1'b0;
    send_frame('1, 0, 0, 0, 0);

    phase = "R11";
    pair_code = 2'b00;
    for (int i = 0; i < 4; i++) send_frame('1, 0, 0, 1, 2'(i + 1));

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog expired in phase %s actual=%0d expected<=20000", phase, cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule